// File: doc/BRIEF.md
# Reaction Time Measurement Counter

This block measures how long a person takes to respond, in hundredths of a second. A fast system clock is divided by a free-running power-of-two prescaler. With a 102.4 kHz clock and a 10-bit prescaler, the prescaler yields one enable tick every 10 ms.

A one-cycle start pulse sets a single run flag. The run flag drives the indicator LED and lets the ticks advance a chain of cascaded decimal (BCD) digits. Pressing the active-low pushbutton clears the run flag. The digits then hold the reaction time until the next reset.

Every digit can also be presented as an active-high seven-segment pattern. A parameter chooses whether the decoders are built. All storage runs on the single system clock, and the tick acts only as an enable.

Top module: `reaction_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the run flag (and so `led_o`) and every digit become 0 at that edge, whatever `go_i` and `btn_n_i` are.
- R2: With `rst` low and `btn_n_i` high, `go_i` high at an edge sets the run flag, and `led_o` is 1 after that edge.
- R3: `btn_n_i` low at an edge with `rst` low clears the run flag at that edge, even when `go_i` is high in the same cycle.
- R4: The prescaler counts clock edges from reset and raises its tick on every 2^DIV_BITS-th cycle. The least significant digit (`bcd_o[3:0]`) advances by one at each edge where the tick and the run flag are both 1.
- R5: A digit that holds 9 when it is enabled returns to 0 at that edge. The next higher digit (digit i sits in `bcd_o[4*i+3:4*i]`) advances at the same edge.
- R6: When every digit holds 9 and an enabled tick arrives, all digits become 0 (the count wraps and does not saturate).
- R7: While the run flag is 0, or on cycles without a tick, the digits keep their value.
- R8: With SEG_EN=1, `seg_o[7*i+6:7*i]` is the segment pattern of digit i. Segment a is the lowest bit and segment g the highest, and a 1 lights a segment. The patterns in hex are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F.
- R9: No digit ever holds a value above 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 1024 × tick rate) |
| rst | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | One-cycle start pulse |
| btn_n_i | input | 1 | Stop pushbutton, active low, already debounced |
| led_o | output | 1 | Indicator drive; 1 while measuring |
| bcd_o | output | 4*DIGITS | Decimal digits, least significant digit in the low nibble |
| seg_o | output | 7*DIGITS | Seven-segment patterns per digit, bit 0 = segment a |

## Verification
The bench builds the block with DIV_BITS=3, DIGITS=2 and SEG_EN=1, so a tick arrives every eight clock cycles. A full pass from 00 through 99 and back to 00 then takes about 800 cycles. This makes the wrap, every tens carry and every segment pattern reachable many times within a short run. Random start, stop and reset pulses also land at every phase of the prescaler, including on the tick cycle itself.

// File: rtl/rt_pkg.sv
package rt_pkg;
   localparam int BCD_W = 4;
   localparam int SEG_W = 7;
   typedef logic [BCD_W-1:0] bcd_t;
   typedef logic [SEG_W-1:0] seg_t;
   localparam bcd_t BCD_TOP = 4'd9;

   // bit 0 = segment a ... bit 6 = segment g, active high
   function automatic seg_t bcd_to_seg(input bcd_t d);
      seg_t s;
      case (d)
         4'd0: s = 7'h3F;
         4'd1: s = 7'h06;
         4'd2: s = 7'h5B;
         4'd3: s = 7'h4F;
         4'd4: s = 7'h66;
         4'd5: s = 7'h6D;
         4'd6: s = 7'h7D;
         4'd7: s = 7'h07;
         4'd8: s = 7'h7F;
         4'd9: s = 7'h6F;
         default: s = 7'h00;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
   parameter int DIV_BITS = 10
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   logic [DIV_BITS-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + DIV_BITS'(1);
   end

   assign tick_o = &cnt_q;

   // R4
   tick_restart_chk: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/rt_run_ctl.sv
module rt_run_ctl (
   input  logic clk,
   input  logic rst,
   input  logic go_i,
   input  logic btn_n_i,
   output logic run_o
);
   logic run_q;

   always_ff @(posedge clk) begin
      if (rst)           run_q <= 1'b0;
      else if (!btn_n_i) run_q <= 1'b0;
      else if (go_i)     run_q <= 1'b1;
   end

   assign run_o = run_q;

   // R3
   press_stops_chk: assert property (@(posedge clk) disable iff (rst)
      !btn_n_i |=> !run_o);
   // R2
   go_starts_chk: assert property (@(posedge clk) disable iff (rst)
      (go_i && btn_n_i) |=> run_o);
endmodule

// File: rtl/rt_bcd_digit.sv
module rt_bcd_digit
   import rt_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic en_i,
   output bcd_t val_o,
   output logic carry_o
);
   bcd_t val_q;

   always_ff @(posedge clk) begin
      if (rst)
         val_q <= '0;
      else if (en_i)
         val_q <= (val_q == BCD_TOP) ? '0 : val_q + 4'd1;
   end

   assign val_o   = val_q;
   assign carry_o = en_i && (val_q == BCD_TOP);

   // R9
   digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      val_o <= BCD_TOP);
   // R5
   digit_rollover_chk: assert property (@(posedge clk) disable iff (rst)
      carry_o |=> (val_o == '0));
   // R7
   digit_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en_i |=> $stable(val_o));
endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
   import rt_pkg::*;
#(
   parameter int DIV_BITS = 10,
   parameter int DIGITS   = 2,
   parameter bit SEG_EN   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    go_i,
   input  logic                    btn_n_i,
   output logic                    led_o,
   output logic [BCD_W*DIGITS-1:0] bcd_o,
   output logic [SEG_W*DIGITS-1:0] seg_o
);
   if (DIV_BITS < 1 || DIV_BITS > 24) begin : g_bad_div
      $error("reaction_timer: DIV_BITS must lie in 1..24");
   end
   if (DIGITS < 1 || DIGITS > 8) begin : g_bad_digits
      $error("reaction_timer: DIGITS must lie in 1..8");
   end

   logic        tick;
   logic        run;
   logic [DIGITS:0] en;

   rt_prescaler #(.DIV_BITS(DIV_BITS)) u_pre (
      .clk(clk), .rst(rst), .tick_o(tick)
   );

   rt_run_ctl u_run (
      .clk(clk), .rst(rst), .go_i(go_i), .btn_n_i(btn_n_i), .run_o(run)
   );

   assign en[0] = tick & run;
   assign led_o = run;

   for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      bcd_t dval;
      rt_bcd_digit u_dig (
         .clk(clk), .rst(rst), .en_i(en[i]),
         .val_o(dval), .carry_o(en[i+1])
      );
      assign bcd_o[BCD_W*i +: BCD_W] = dval;
      if (SEG_EN) begin : g_seg
         assign seg_o[SEG_W*i +: SEG_W] = bcd_to_seg(dval);
      end else begin : g_noseg
         assign seg_o[SEG_W*i +: SEG_W] = '0;
      end
   end

   // R6
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
      en[DIGITS] |=> (bcd_o == '0));
   // R1
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> (!led_o && bcd_o == '0));
endmodule

// File: tb/sim_reaction_timer.sv
module sim_reaction_timer;
   localparam int DIV_BITS = 3;
   localparam int DIGITS   = 2;
   localparam int PMAX     = (1 << DIV_BITS) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1, go = 1'b0, btn_n = 1'b1;
   logic led;
   logic [4*DIGITS-1:0] bcd;
   logic [7*DIGITS-1:0] seg;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   int m_pc = 0;
   bit m_run = 1'b0;
   int m_d [DIGITS];
   string led_tag, dig_tag;

   always #4 clk = ~clk;

   reaction_timer #(.DIV_BITS(DIV_BITS), .DIGITS(DIGITS), .SEG_EN(1'b1)) u0 (
      .clk(clk), .rst(rst), .go_i(go), .btn_n_i(btn_n),
      .led_o(led), .bcd_o(bcd), .seg_o(seg)
   );

   function automatic logic [6:0] ref_seg(input int v);
      case (v)
         0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
         4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
         8: return 7'h7F; 9: return 7'h6F;
         default: return 7'h00;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(led_tag, int'(led), int'(m_run), "led");
      for (int i = 0; i < DIGITS; i++) begin
         chk(dig_tag, int'(bcd[4*i +: 4]), m_d[i], $sformatf("digit%0d", i));
         chk("R9", int'(bcd[4*i +: 4] <= 4'd9), 1, $sformatf("digit%0d range", i));
         chk("R8", int'(seg[7*i +: 7]), int'(ref_seg(m_d[i])), $sformatf("seg%0d", i));
      end
   endtask

   // drive at negedge, advance model over the edge, check at next negedge
   task automatic step(input bit r, input bit g, input bit b);
      bit tick, all9;
      int nd [DIGITS];
      bit carry;
      rst = r; go = g; btn_n = b;
      tick = (m_pc == PMAX);
      all9 = 1'b1;
      for (int i = 0; i < DIGITS; i++) begin
         nd[i] = m_d[i];
         if (m_d[i] != 9) all9 = 1'b0;
      end
      dig_tag = "R7";
      if (r) begin
         dig_tag = "R1";
         for (int i = 0; i < DIGITS; i++) nd[i] = 0;
      end else if (tick && m_run) begin
         carry = 1'b1;
         dig_tag = all9 ? "R6" : (m_d[0] == 9 ? "R5" : "R4");
         for (int i = 0; i < DIGITS; i++) begin
            if (carry) begin
               if (m_d[i] == 9) nd[i] = 0;
               else begin nd[i] = m_d[i] + 1; carry = 1'b0; end
            end
         end
      end
      led_tag = r ? "R1" : (!b ? "R3" : "R2");
      @(posedge clk);
      m_pc  = r ? 0 : (m_pc + 1) % (PMAX + 1);
      m_run = r ? 1'b0 : (!b ? 1'b0 : (g ? 1'b1 : m_run));
      for (int i = 0; i < DIGITS; i++) m_d[i] = nd[i];
      @(negedge clk);
      compare();
   endtask

   initial begin
      for (int i = 0; i < DIGITS; i++) m_d[i] = 0;
      @(negedge clk);
      // R1: reset state, reset beats go
      step(1, 0, 1); step(1, 0, 1);
      step(1, 1, 1);
      // R3: press in same cycle as go wins
      step(0, 1, 0);
      step(0, 0, 1);
      // R2/R4/R5/R6: start and run through a full wrap
      step(0, 1, 1);
      for (int k = 0; k < (PMAX + 1) * 100 + 20; k++) step(0, 0, 1);
      // R3/R7: stop and hold
      step(0, 0, 0);
      for (int k = 0; k < 40; k++) step(0, 0, 1);
      // random phase
      void'($urandom(32'd2024));
      for (int k = 0; k < 8000; k++) begin
         automatic int rr = $urandom % 600;
         automatic int gg = $urandom % 30;
         automatic int bb = $urandom % 90;
         step(rr == 0, gg == 0, bb != 0);
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule